// File: doc/BRIEF.md
# Page Write Collector and Word Commit Sequencer

This block sits behind a serial-bus target front-end of a non-volatile memory. Once the front-end has decoded a write target address, it pulses a load strobe. Every received data byte then arrives as a one-cycle strobe. The block places each byte in a local page buffer at the current column and records it in a per-byte valid mask. The column advances after every byte and wraps inside the page. The page part of the address never changes during a command.

Data reaches the array only when the front-end reports a STOP. At that point the block walks the touched 4-byte words in ascending order. It gives each word one fixed-length slot of `WORD_CYCLES` clocks and issues a single word-write request, with byte enables, in the first clock of the slot. A word with no received byte gets no slot. Bytes that were not received are left out of the byte enables, so the array keeps their old contents. `busy_o` covers the whole commit, and the front-end uses it to refuse polling. A START or repeated START that arrives before STOP throws the buffered data away.

An external protection check drives `allow_i` from the word address on `wr_word_addr_o`. A word that is refused still uses up its slot, so the commit time depends only on how many words were touched.

Top module: `page_commit_seq`

## Requirements
- R1: After reset, `busy_o` and `wr_req_o` are low and nothing is buffered.
- R2: `load_i` takes the page (address bits above the low 6) and the start column (low 6 bits) from `start_addr_i`. The k-th accepted byte after it goes to column (start + k) mod 64 of the same page. For example, the bytes after 0x01FF go to 0x01C0, 0x01C1 and so on. The word address sent to the array is {page, column[5:2]}.
- R3: When more than 64 bytes arrive before STOP, a later byte that lands on an already-filled column replaces the earlier one. Only the last value written to each column is committed.
- R4: Nothing is written unless STOP arrives. A `restart_i` pulse received while collecting throws the buffer away, and a later STOP then commits nothing. A new `load_i` before STOP also throws away the bytes collected so far. A STOP with no received bytes starts no commit.
- R5: The commit issues exactly one request for each 4-byte word that holds at least one received byte, in ascending word order. In `wr_be_o`, bit k is set exactly when the byte at column word*4+k was received. That byte appears at `wr_data_o[8k+7:8k]`.
- R6: `busy_o` rises in the cycle after STOP is sampled and stays high for exactly (touched words × `WORD_CYCLES`) cycles. `wr_req_o` is high only while busy, and only in the first cycle of a slot.
- R7: If `allow_i` is low in the first cycle of a slot, that word's request is suppressed, but its slot still uses up `WORD_CYCLES` cycles.
- R8: While `busy_o` is high, `load_i`, `byte_i`, `stop_i` and `restart_i` are ignored. They change neither the words being committed nor the commit that follows.
- R9: Byte strobes and STOP received with no load since the last commit or discard are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Address phase complete; start collecting |
| start_addr_i | input | ADDR_W | Write target byte address |
| byte_i | input | 1 | One received data byte |
| byte_data_i | input | 8 | Data byte value |
| stop_i | input | 1 | STOP seen on the bus; commit |
| restart_i | input | 1 | START or repeated START before STOP; discard |
| allow_i | input | 1 | Protection permits writing the word on `wr_word_addr_o` |
| busy_o | output | 1 | Commit in progress |
| wr_req_o | output | 1 | Word-write request to the array |
| wr_word_addr_o | output | ADDR_W-2 | Word address of the current slot |
| wr_data_o | output | 32 | Word data, column word*4+k in byte lane k |
| wr_be_o | output | 4 | Byte enables, one per received byte |

## Verification
The assertions assume that the front-end raises at most one of `load_i`, `byte_i`, `stop_i` and `restart_i` in any cycle. They also assume that `allow_i` is a settled combinational function of `wr_word_addr_o`. The bench keeps to both conditions: it drives each strobe alone for one cycle, just after a rising edge, and computes `allow_i` from a per-word map indexed by the presented word address. To check the ignored-while-busy rule, the bench deliberately sends strobes during a commit. It uses a commit that covers enough words that every injected strobe falls inside the busy window.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_COMMIT  = 2'd2
  } pcs_state_e;

  // Column step inside a page: increments and wraps at the page size.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned modulus);
    return (v + 1) % modulus;
  endfunction

  // Column of byte lane k of word w.
  function automatic int unsigned lane_col(input int unsigned w, input int unsigned k,
                                           input int unsigned lanes);
    return w * lanes + k;
  endfunction

endpackage

// File: rtl/pcs_page_buffer.sv
module pcs_page_buffer #(
  parameter int PAGE_BYTES = 64,
  parameter int WORD_BYTES = 4,
  parameter int COL_W      = 6,
  parameter int NWORDS     = 16,
  parameter int WIDX_W     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear_i,
  input  logic                    wr_en_i,
  input  logic [COL_W-1:0]        wr_col_i,
  input  logic [7:0]              wr_byte_i,
  input  logic [WIDX_W-1:0]       rd_word_i,
  output logic [8*WORD_BYTES-1:0] rd_data_o,
  output logic [WORD_BYTES-1:0]   rd_be_o,
  output logic [NWORDS-1:0]       touch_o,
  output logic                    any_valid_o
);

  logic [7:0]            mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_col_i] <= wr_byte_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid_q <= '0;
    else if (clear_i) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_col_i] <= 1'b1;
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_touch
    assign touch_o[w] = |valid_q[w*WORD_BYTES +: WORD_BYTES];
  end

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    logic [COL_W-1:0] lane_col;
    assign lane_col = COL_W'(pcs_pkg::lane_col(32'(rd_word_i), k, WORD_BYTES));
    assign rd_data_o[8*k +: 8] = mem[lane_col];
    assign rd_be_o[k]          = valid_q[lane_col];
  end

  assign any_valid_o = |valid_q;

  // R2: an accepted byte marks its own column as received.
  p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !clear_i |=> valid_q[$past(wr_col_i)]);

  // R4: a clear leaves nothing buffered.
  p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !any_valid_o);

endmodule

// File: rtl/pcs_word_picker.sv
module pcs_word_picker #(
  parameter int NWORDS = 16,
  parameter int IDX_W  = 4
) (
  input  logic [NWORDS-1:0] pend_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              any_o
);

  // Lowest pending word wins, giving ascending commit order.
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int w = NWORDS - 1; w >= 0; w--) begin
      if (pend_i[w]) begin
        idx_o = IDX_W'(w);
        any_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcs_commit_ctrl.sv
module pcs_commit_ctrl #(
  parameter int ADDR_W      = 14,
  parameter int COL_W       = 6,
  parameter int NWORDS      = 16,
  parameter int WIDX_W      = 4,
  parameter int WORD_CYCLES = 16,
  parameter int SLOT_W      = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [ADDR_W-1:0]       start_addr_i,
  input  logic                    byte_i,
  input  logic                    stop_i,
  input  logic                    restart_i,
  input  logic [NWORDS-1:0]       touch_i,
  input  logic                    any_valid_i,
  input  logic [WIDX_W-1:0]       pick_idx_i,
  input  logic                    pick_any_i,
  output logic                    buf_wr_en_o,
  output logic                    buf_clear_o,
  output logic [COL_W-1:0]        col_o,
  output logic [ADDR_W-COL_W-1:0] page_o,
  output logic [NWORDS-1:0]       pend_o,
  output logic                    busy_o,
  output logic                    slot_first_o
);
  import pcs_pkg::*;

  localparam int PAGE_W     = ADDR_W - COL_W;
  localparam int PAGE_BYTES = 1 << COL_W;

  pcs_state_e          state_q;
  logic [COL_W-1:0]    col_q;
  logic [PAGE_W-1:0]   page_q;
  logic [NWORDS-1:0]   pend_q;
  logic [SLOT_W-1:0]   slot_q;

  // Named events, one per decision the sequencer takes.
  logic in_collect, in_commit;
  logic ev_discard, ev_stop, ev_commit_start, ev_empty_stop;
  logic ev_load, ev_accept, ev_slot_last, ev_commit_done;
  logic [NWORDS-1:0] pick_oh, pend_next;

  assign in_collect      = (state_q == ST_COLLECT);
  assign in_commit       = (state_q == ST_COMMIT);
  assign ev_discard      = in_collect && restart_i;
  assign ev_stop         = in_collect && !restart_i && stop_i;
  assign ev_commit_start = ev_stop && any_valid_i;
  assign ev_empty_stop   = ev_stop && !any_valid_i;
  assign ev_load         = load_i && ((state_q == ST_IDLE) ||
                                      (in_collect && !restart_i && !stop_i));
  assign ev_accept       = in_collect && !restart_i && !stop_i && !load_i && byte_i;
  assign pick_oh         = NWORDS'(1) << pick_idx_i;
  assign pend_next       = pend_q & ~pick_oh;
  assign ev_slot_last    = in_commit && (slot_q == SLOT_W'(WORD_CYCLES - 1));
  assign ev_commit_done  = ev_slot_last && (pend_next == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      page_q  <= '0;
      pend_q  <= '0;
      slot_q  <= '0;
    end else begin
      if (ev_load) begin
        state_q <= ST_COLLECT;
        col_q   <= start_addr_i[COL_W-1:0];
        page_q  <= start_addr_i[ADDR_W-1:COL_W];
      end else if (ev_accept) begin
        col_q <= COL_W'(wrap_inc(32'(col_q), PAGE_BYTES));
      end else if (ev_discard || ev_empty_stop) begin
        state_q <= ST_IDLE;
      end else if (ev_commit_start) begin
        state_q <= ST_COMMIT;
        pend_q  <= touch_i;
        slot_q  <= '0;
      end else if (in_commit) begin
        if (ev_slot_last) begin
          slot_q <= '0;
          pend_q <= pend_next;
          if (ev_commit_done) state_q <= ST_IDLE;
        end else begin
          slot_q <= slot_q + SLOT_W'(1);
        end
      end
    end
  end

  assign buf_wr_en_o  = ev_accept;
  assign buf_clear_o  = ev_load || ev_discard || ev_empty_stop || ev_commit_done;
  assign col_o        = col_q;
  assign page_o       = page_q;
  assign pend_o       = pend_q;
  assign busy_o       = in_commit;
  assign slot_first_o = in_commit && (slot_q == '0);

  // R4: a commit only ever begins right after a STOP.
  p_commit_needs_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));

  // R4: a discard never leads into a commit.
  p_discard_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_discard |=> !busy_o);

  // R5: the pending word set never gains members during a commit.
  p_pend_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> ((pend_q & ~$past(pend_q)) == '0));

  // R5: the word being served is one that is still pending.
  p_pick_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> pick_any_i && pend_q[pick_idx_i]);

  // R6: the slot counter restarts at each slot boundary.
  p_slot_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_slot_last && !ev_commit_done |=> slot_first_o);

  // R8: the target page is frozen while busy.
  p_busy_page_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(page_o));

endmodule

// File: rtl/page_commit_seq.sv
module page_commit_seq #(
  parameter int ADDR_W      = 14,
  parameter int PAGE_BYTES  = 64,
  parameter int WORD_BYTES  = 4,
  parameter int WORD_CYCLES = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic [ADDR_W-1:0]           start_addr_i,
  input  logic                        byte_i,
  input  logic [7:0]                  byte_data_i,
  input  logic                        stop_i,
  input  logic                        restart_i,
  input  logic                        allow_i,
  output logic                        busy_o,
  output logic                        wr_req_o,
  output logic [ADDR_W-3:0]           wr_word_addr_o,
  output logic [31:0]                 wr_data_o,
  output logic [3:0]                  wr_be_o
);

  localparam int COL_W  = $clog2(PAGE_BYTES);
  localparam int NWORDS = PAGE_BYTES / WORD_BYTES;
  localparam int WIDX_W = $clog2(NWORDS);
  localparam int PAGE_W = ADDR_W - COL_W;
  localparam int SLOT_W = $clog2(WORD_CYCLES + 1);

  logic                    buf_wr_en, buf_clear, any_valid, pick_any, slot_first;
  logic [COL_W-1:0]        col;
  logic [PAGE_W-1:0]       page;
  logic [NWORDS-1:0]       touch, pend;
  logic [WIDX_W-1:0]       pick_idx;
  logic [8*WORD_BYTES-1:0] rd_data;
  logic [WORD_BYTES-1:0]   rd_be;

  pcs_commit_ctrl #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .NWORDS(NWORDS), .WIDX_W(WIDX_W),
    .WORD_CYCLES(WORD_CYCLES), .SLOT_W(SLOT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
    .byte_i(byte_i), .stop_i(stop_i), .restart_i(restart_i),
    .touch_i(touch), .any_valid_i(any_valid),
    .pick_idx_i(pick_idx), .pick_any_i(pick_any),
    .buf_wr_en_o(buf_wr_en), .buf_clear_o(buf_clear),
    .col_o(col), .page_o(page), .pend_o(pend),
    .busy_o(busy_o), .slot_first_o(slot_first)
  );

  pcs_page_buffer #(
    .PAGE_BYTES(PAGE_BYTES), .WORD_BYTES(WORD_BYTES), .COL_W(COL_W),
    .NWORDS(NWORDS), .WIDX_W(WIDX_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .clear_i(buf_clear), .wr_en_i(buf_wr_en),
    .wr_col_i(col), .wr_byte_i(byte_data_i), .rd_word_i(pick_idx),
    .rd_data_o(rd_data), .rd_be_o(rd_be), .touch_o(touch), .any_valid_o(any_valid)
  );

  pcs_word_picker #(.NWORDS(NWORDS), .IDX_W(WIDX_W)) u_pick (
    .pend_i(pend), .idx_o(pick_idx), .any_o(pick_any)
  );

  assign wr_req_o       = slot_first && allow_i;
  assign wr_word_addr_o = (ADDR_W-2)'({page, pick_idx});
  assign wr_data_o      = 32'(rd_data);
  assign wr_be_o        = 4'(rd_be);

  // R6: requests only while busy.
  p_req_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> busy_o);

  // R5: every request carries at least one received byte.
  p_req_has_bytes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> (wr_be_o != '0));

  // R7: a refused word never produces a request.
  p_refused_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !allow_i |-> !wr_req_o);

endmodule

// File: tb/page_commit_seq_bench.sv
module page_commit_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 14;
  localparam int WC = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, load_i, byte_i, stop_i, restart_i, allow_i;
  logic [AW-1:0] start_addr_i;
  logic [7:0] byte_data_i;
  logic busy_o, wr_req_o;
  logic [AW-3:0] wr_word_addr_o;
  logic [31:0] wr_data_o;
  logic [3:0] wr_be_o;
  logic [15:0] allow_map;

  page_commit_seq #(.ADDR_W(AW), .WORD_CYCLES(WC)) u_page_commit_seq (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
    .byte_i(byte_i), .byte_data_i(byte_data_i), .stop_i(stop_i),
    .restart_i(restart_i), .allow_i(allow_i), .busy_o(busy_o),
    .wr_req_o(wr_req_o), .wr_word_addr_o(wr_word_addr_o),
    .wr_data_o(wr_data_o), .wr_be_o(wr_be_o)
  );

  assign allow_i = allow_map[wr_word_addr_o[3:0]];

  int tests = 0;
  int fails = 0;
  int mon_n = 0;
  int busy_cnt = 0;
  logic [11:0] mon_addr [32];
  logic [31:0] mon_data [32];
  logic [3:0]  mon_be   [32];

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o) busy_cnt++;
      if (wr_req_o) begin
        if (mon_n < 32) begin
          mon_addr[mon_n] = wr_word_addr_o;
          mon_data[mon_n] = wr_data_o;
          mon_be[mon_n]   = wr_be_o;
        end
        mon_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send_load(input logic [AW-1:0] a);
    load_i = 1'b1; start_addr_i = a; tick(); load_i = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] d);
    byte_i = 1'b1; byte_data_i = d; tick(); byte_i = 1'b0;
  endtask
  task automatic send_stop();
    stop_i = 1'b1; tick(); stop_i = 1'b0;
  endtask
  task automatic send_restart();
    restart_i = 1'b1; tick(); restart_i = 1'b0;
  endtask

  function automatic logic [7:0] bval(input int seed, input int i);
    return 8'(seed * 37 + i * 13 + 5);
  endfunction

  task automatic clear_mon();
    mon_n = 0; busy_cnt = 0;
  endtask

  task automatic drain();
    while (busy_o) tick();
    tick();
  endtask

  // Full transaction with expected words computed from column arithmetic.
  task automatic run_txn(input logic [AW-1:0] a, input int n, input int seed,
                         input logic [15:0] amap, input bit poke_busy);
    logic [7:0] ed [64];
    bit ev [64];
    int touched, k;
    logic [31:0] exp_d, msk;
    logic [3:0] exp_be;
    logic [11:0] exp_a;
    string tg;
    for (int i = 0; i < 64; i++) begin ev[i] = 1'b0; ed[i] = 8'h00; end
    allow_map = amap;
    clear_mon();
    send_load(a);
    for (int i = 0; i < n; i++) begin
      int c;
      c = (int'(a[5:0]) + i) % 64;
      ed[c] = bval(seed, i);
      ev[c] = 1'b1;
      send_byte(bval(seed, i));
    end
    send_stop();
    if (poke_busy) begin
      // R8: strobes during the commit window
      send_load(14'h3FC0); send_byte(8'hA5); send_byte(8'h5A); send_stop();
    end
    drain();
    touched = 0; k = 0;
    tg = (n > 64) ? "R3" : "R5";
    for (int w = 0; w < 16; w++) begin
      exp_be = {ev[w*4+3], ev[w*4+2], ev[w*4+1], ev[w*4]};
      if (exp_be != 4'b0) begin
        touched++;
        if (amap[w]) begin
          exp_d = {ed[w*4+3], ed[w*4+2], ed[w*4+1], ed[w*4]};
          msk   = {{8{exp_be[3]}}, {8{exp_be[2]}}, {8{exp_be[1]}}, {8{exp_be[0]}}};
          exp_a = {a[13:6], 4'(w)};
          if (k < 32) begin
            chk(mon_addr[k] == exp_a, "R2", mon_addr[k], exp_a);
            chk(mon_be[k] == exp_be, "R5", mon_be[k], exp_be);
            chk((mon_data[k] & msk) == (exp_d & msk), tg, mon_data[k] & msk, exp_d & msk);
          end
          k++;
        end
      end
    end
    chk(busy_cnt == touched * WC, "R6", busy_cnt, touched * WC);
    chk(mon_n == k, (amap != 16'hFFFF) ? "R7" : "R5", mon_n, k);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_i = 0; byte_i = 0; stop_i = 0; restart_i = 0;
    start_addr_i = '0; byte_data_i = '0; allow_map = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1;
    chk(busy_o == 1'b0, "R1", busy_o, 0);
    chk(wr_req_o == 1'b0, "R1", wr_req_o, 0);
    rst_n = 1'b1;
    tick();
    // R1: STOP right after reset commits nothing (nothing buffered)
    clear_mon(); send_stop(); tick(); tick();
    chk(busy_cnt == 0, "R1", busy_cnt, 0);

    // R9: bytes and STOP without a load are ignored
    clear_mon();
    send_byte(8'h11); send_byte(8'h22); send_stop(); tick(); tick();
    chk(mon_n == 0, "R9", mon_n, 0);
    chk(busy_cnt == 0, "R9", busy_cnt, 0);

    // R4: restart before STOP discards
    clear_mon();
    send_load(14'h0123); send_byte(8'h01); send_byte(8'h02); send_restart();
    send_stop(); tick(); tick();
    chk(mon_n == 0, "R4", mon_n, 0);
    chk(busy_cnt == 0, "R4", busy_cnt, 0);

    // R4: STOP with no data bytes
    clear_mon();
    send_load(14'h0040); send_stop(); tick(); tick();
    chk(busy_cnt == 0, "R4", busy_cnt, 0);

    // R4: reload before STOP drops earlier bytes
    clear_mon();
    send_load(14'h0100); send_byte(8'hAA); send_byte(8'hBB);
    send_load(14'h0240); send_byte(8'h3C); send_stop(); drain();
    chk(mon_n == 1, "R4", mon_n, 1);
    chk(mon_addr[0] == 12'h090, "R4", mon_addr[0], 12'h090);
    chk(mon_be[0] == 4'b0001, "R4", mon_be[0], 4'b0001);
    chk(mon_data[0][7:0] == 8'h3C, "R4", mon_data[0][7:0], 8'h3C);
    chk(busy_cnt == WC, "R6", busy_cnt, WC);

    // R2: wrap at the end of page 0x01C0
    clear_mon();
    send_load(14'h01FF); send_byte(8'h77); send_byte(8'h88); send_stop(); drain();
    chk(mon_n == 2, "R2", mon_n, 2);
    chk(mon_addr[0] == 12'h070, "R2", mon_addr[0], 12'h070);
    chk(mon_be[0] == 4'b0001 && mon_data[0][7:0] == 8'h88, "R2", mon_data[0][7:0], 8'h88);
    chk(mon_addr[1] == 12'h07F, "R2", mon_addr[1], 12'h07F);
    chk(mon_be[1] == 4'b1000 && mon_data[1][31:24] == 8'h77, "R2", mon_data[1][31:24], 8'h77);

    // R3: 65 bytes overwrite column of the first
    run_txn(14'h0700, 65, 3, 16'hFFFF, 1'b0);

    // R8: strobes while busy are ignored, and nothing follows
    run_txn(14'h0500, 16, 9, 16'hFFFF, 1'b1);
    clear_mon(); send_stop(); tick(); tick();
    chk(busy_cnt == 0, "R8", busy_cnt, 0);

    // R7: protection patterns over a full page
    run_txn(14'h1C00, 64, 5, 16'h0F0F, 1'b0);
    run_txn(14'h1C00, 64, 6, 16'h0000, 1'b0);
    run_txn(14'h3000, 40, 7, 16'h8001, 1'b0);

    // Sweep every start column with a spread of lengths
    for (int c = 0; c < 64; c++) begin
      for (int s = 0; s < 6; s++) begin
        int lens [6] = '{1, 3, 4, 6, 63, 66};
        logic [AW-1:0] a;
        a = AW'(((c * 5) % 256) * 64 + c);
        run_txn(a, lens[s], c * 7 + s, 16'hFFFF, 1'b0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule